// File: doc/BRIEF.md
# Masked Burst Line Writer

This block takes one partial store aimed at a single memory line and turns it into burst traffic on a beat-wide memory data interface. A request names a line, a starting byte inside that line, a byte count and the write data placed at its line byte positions. The block works out which byte lanes of each beat are to be written. It then issues one write command and streams the beats with a byte mask per beat.

When every written byte falls inside one half of the line, the masked path sends a chopped half-length burst. Otherwise it sends the full burst. A mode input, sampled when the request is taken, selects a fallback for memories that cannot honour byte masks. In that mode the block reads the whole line, patches the requested bytes into the returned data and writes the whole line back with every lane enabled. A request that spills past the end of the line, or that has zero length, is taken and rejected with an error pulse.

Top module: `mbw_line_writer`

## Requirements
- R1: After reset req_ready is 1 and cmd_valid, wr_valid, done and req_err are 0. req_ready is 1 only while the block is idle. A request is taken on a cycle with req_valid and req_ready both high.
- R2: A request with req_len of 0, or with req_off + req_len larger than the line size in bytes, is taken. It raises req_err for exactly one cycle, in the cycle after it is taken. It issues no command, no write beat and no done, and it leaves memory unchanged.
- R3: Line byte i is written with byte i of req_data (bits 8i+7..8i) exactly when req_off <= i < req_off + req_len. Beat b carries line bytes b*BB to b*BB+BB-1, where BB = DATA_W/8. Bit j of wr_mask enables byte j of that beat (bits 8j+7..8j of wr_data).
- R4: In masked mode (merge_mode 0 at acceptance), if every enabled byte lies in the lower half of the line, the write command has cmd_chop=1 and cmd_half=0 and carries beats 0..BEATS/2-1. If every enabled byte lies in the upper half, the command has cmd_chop=1 and cmd_half=1 and carries beats BEATS/2..BEATS-1. Otherwise cmd_chop=0 and all BEATS beats are sent in order from beat 0.
- R5: Each legal request produces exactly one write command (cmd_write=1), so no store is ever split across commands. cmd_line equals the req_line that was taken.
- R6: In merge mode (merge_mode 1 at acceptance; later changes are ignored), the block first issues a full read command (cmd_write=0, cmd_chop=0) and takes BEATS read beats in order. It then writes the full line with wr_mask all ones. The written line holds the old bytes with the requested range replaced.
- R7: In merge mode the write command is not presented until all BEATS read beats have returned.
- R8: done is high for exactly one cycle, the cycle after the last write beat is accepted.
- R9: While cmd_valid is high and cmd_ready is low, cmd_valid and all command fields hold. While wr_valid is high and wr_ready is low, wr_valid, wr_data and wr_mask hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| merge_mode | input | 1 | 1 selects read-merge-write, 0 selects masked writes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_line | input | LADDR_W | Line address |
| req_off | input | log2(LINE_BYTES) | First byte within the line |
| req_len | input | log2(LINE_BYTES)+1 | Byte count |
| req_data | input | LINE_BYTES*8 | Store data at line byte positions |
| req_err | output | 1 | One-cycle pulse: request rejected |
| done | output | 1 | One-cycle pulse: last write beat accepted |
| cmd_valid | output | 1 | Memory command valid |
| cmd_ready | input | 1 | Memory command accepted |
| cmd_write | output | 1 | 1 write, 0 read |
| cmd_line | output | LADDR_W | Command line address |
| cmd_chop | output | 1 | Half-length burst |
| cmd_half | output | 1 | For a chopped burst, 1 selects the upper half |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_data | output | DATA_W | Write beat data |
| wr_mask | output | DATA_W/8 | Per-byte write enables |
| rd_valid | input | 1 | Read beat returned |
| rd_data | input | DATA_W | Read beat data |

## Verification
The bench builds the block with a 32-bit beat and four beats per line, which gives a 16-byte line whose halves are two beats each. At that size every start offset can be swept against every length from zero past the line end, in both modes. That covers all lower-half, upper-half and straddling chop cases, every overflow rejection and every partial first and last beat. Stalls on the command and write channels and gaps in the read return are driven in fixed rotating patterns, so the hold rules and the read-before-write order are exercised across many phase alignments.

// File: rtl/mbw_pkg.sv
`timescale 1ns/1ps
package mbw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RCMD,
      ST_RDAT,
      ST_WCMD,
      ST_WDAT
   } mbw_state_e;
endpackage

// File: rtl/mbw_mask_gen.sv
`timescale 1ns/1ps
// Byte-enable vector, range check and chop decision for one request.
module mbw_mask_gen #(
   parameter int LINE_BYTES = 64,
   parameter bit ALLOW_CHOP = 1'b1,
   localparam int OFF_W = $clog2(LINE_BYTES),
   localparam int LEN_W = OFF_W + 1
) (
   input  logic [OFF_W-1:0]      off,
   input  logic [LEN_W-1:0]      len,
   output logic [LINE_BYTES-1:0] byte_en,
   output logic                  bad,
   output logic                  chop,
   output logic                  upper
);
   localparam int SUM_W = OFF_W + 2;
   localparam int HALF_BYTES = LINE_BYTES / 2;

   logic [SUM_W-1:0] stop;

   assign stop = SUM_W'(off) + SUM_W'(len);
   assign bad  = (len == '0) || (stop > SUM_W'(LINE_BYTES));

   for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
      assign byte_en[i] = (SUM_W'(i) >= SUM_W'(off)) && (SUM_W'(i) < stop);
   end

   if (ALLOW_CHOP) begin : g_chop
      logic low_only, high_only;
      assign low_only  = stop <= SUM_W'(HALF_BYTES);
      assign high_only = SUM_W'(off) >= SUM_W'(HALF_BYTES);
      assign chop      = !bad && (low_only || high_only);
      assign upper     = high_only;
   end else begin : g_nochop
      assign chop  = 1'b0;
      assign upper = 1'b0;
   end
endmodule

// File: rtl/mbw_line_buf.sv
`timescale 1ns/1ps
// Line data and enable store; merges returned read beats into unwritten lanes.
module mbw_line_buf #(
   parameter int DATA_W = 64,
   parameter int BEATS  = 8,
   localparam int BB = DATA_W / 8,
   localparam int LINE_BYTES = BB * BEATS,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [LINE_BYTES*8-1:0] load_data,
   input  logic [LINE_BYTES-1:0]   load_be,
   input  logic                    rd_en,
   input  logic [BEAT_W-1:0]       beat,
   input  logic [DATA_W-1:0]       rd_data,
   output logic [DATA_W-1:0]       out_data,
   output logic [BB-1:0]           out_be
);
   logic [LINE_BYTES*8-1:0] data_q;
   logic [LINE_BYTES-1:0]   be_q;

   for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            be_q[i] <= 1'b0;
         end else if (load) begin
            be_q[i] <= load_be[i];
         end
      end
      always_ff @(posedge clk) begin
         if (load) begin
            data_q[8*i +: 8] <= load_data[8*i +: 8];
         end else if (rd_en && (beat == BEAT_W'(i / BB)) && !be_q[i]) begin
            data_q[8*i +: 8] <= rd_data[8*(i % BB) +: 8];
         end
      end
   end

   assign out_data = data_q[int'(beat)*DATA_W +: DATA_W];
   assign out_be   = be_q[int'(beat)*BB +: BB];
endmodule

// File: rtl/mbw_ctrl.sv
`timescale 1ns/1ps
// Request acceptance, read phase, write command and beat sequencing.
module mbw_ctrl
   import mbw_pkg::*;
#(
   parameter int BEATS = 8,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_bad,
   input  logic              req_chop,
   input  logic              req_upper,
   input  logic              mode,
   output logic              take,
   output logic              req_err,
   output logic              done,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic              cmd_write,
   output logic              cmd_chop,
   output logic              cmd_half,
   output logic              wr_valid,
   input  logic              wr_ready,
   input  logic              rd_valid,
   output logic              rd_take,
   output logic              merge_q,
   output logic [BEAT_W-1:0] beat
);
   localparam logic [BEAT_W-1:0] HALF = BEAT_W'(BEATS / 2);
   localparam logic [BEAT_W-1:0] TOP  = BEAT_W'(BEATS - 1);

   mbw_state_e        state_q;
   logic [BEAT_W-1:0] beat_q, last_beat;
   logic              chop_q, upper_q, err_q, done_q;
   logic [BEAT_W:0]   rd_seen_q;

   assign req_ready = (state_q == ST_IDLE);
   assign take      = req_valid && req_ready;
   assign cmd_valid = (state_q == ST_RCMD) || (state_q == ST_WCMD);
   assign cmd_write = (state_q == ST_WCMD);
   assign cmd_chop  = chop_q;
   assign cmd_half  = upper_q;
   assign wr_valid  = (state_q == ST_WDAT);
   assign rd_take   = rd_valid && (state_q == ST_RDAT);
   assign beat      = beat_q;
   assign req_err   = err_q;
   assign done      = done_q;
   assign last_beat = (chop_q && !upper_q) ? HALF - 1'b1 : TOP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         beat_q    <= '0;
         chop_q    <= 1'b0;
         upper_q   <= 1'b0;
         merge_q   <= 1'b0;
         err_q     <= 1'b0;
         done_q    <= 1'b0;
         rd_seen_q <= '0;
      end else begin
         err_q  <= 1'b0;
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (take) begin
               err_q     <= req_bad;
               rd_seen_q <= '0;
               if (!req_bad) begin
                  merge_q <= mode;
                  chop_q  <= !mode && req_chop;
                  upper_q <= !mode && req_chop && req_upper;
                  state_q <= mode ? ST_RCMD : ST_WCMD;
               end
            end
            ST_RCMD: if (cmd_ready) begin
               beat_q  <= '0;
               state_q <= ST_RDAT;
            end
            ST_RDAT: if (rd_valid) begin
               rd_seen_q <= rd_seen_q + 1'b1;
               beat_q    <= beat_q + 1'b1;
               if (beat_q == TOP) state_q <= ST_WCMD;
            end
            ST_WCMD: if (cmd_ready) begin
               beat_q  <= (chop_q && upper_q) ? HALF : '0;
               state_q <= ST_WDAT;
            end
            ST_WDAT: if (wr_ready) begin
               if (beat_q == last_beat) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1: at most one of idle, command and write phases is visible.
   a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready, cmd_valid, wr_valid}));

   // R7: the merge write command waits for every read beat.
   a_r7_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write && merge_q) |-> (rd_seen_q == (BEAT_W+1)'(BEATS)));

   // R8: done follows an accepted write beat.
   a_r8_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wr_valid && wr_ready));

   // R2: an error pulse leaves the block idle with no traffic.
   a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (req_ready && !cmd_valid && !wr_valid && !done));
endmodule

// File: rtl/mbw_line_writer.sv
`timescale 1ns/1ps
// Top: partial line stores to masked or read-merge-write bursts.
module mbw_line_writer #(
   parameter int  DATA_W     = 64,
   parameter int  BEATS      = 8,
   parameter int  LADDR_W    = 26,
   parameter bit  ALLOW_CHOP = 1'b1,
   localparam int BB         = DATA_W / 8,
   localparam int LINE_BYTES = BB * BEATS,
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int LEN_W      = OFF_W + 1,
   localparam int BEAT_W     = $clog2(BEATS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    merge_mode,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [LADDR_W-1:0]      req_line,
   input  logic [OFF_W-1:0]        req_off,
   input  logic [LEN_W-1:0]        req_len,
   input  logic [LINE_BYTES*8-1:0] req_data,
   output logic                    req_err,
   output logic                    done,
   output logic                    cmd_valid,
   input  logic                    cmd_ready,
   output logic                    cmd_write,
   output logic [LADDR_W-1:0]      cmd_line,
   output logic                    cmd_chop,
   output logic                    cmd_half,
   output logic                    wr_valid,
   input  logic                    wr_ready,
   output logic [DATA_W-1:0]       wr_data,
   output logic [BB-1:0]           wr_mask,
   input  logic                    rd_valid,
   input  logic [DATA_W-1:0]       rd_data
);
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("mbw_line_writer: DATA_W must be a multiple of 8");
   end
   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("mbw_line_writer: BEATS must be a power of two of at least 2");
   end

   logic [LINE_BYTES-1:0] byte_en;
   logic                  bad, chop, upper, take, rd_take, merge_q;
   logic [BEAT_W-1:0]     beat;
   logic [BB-1:0]         buf_be;
   logic [LADDR_W-1:0]    line_q;

   mbw_mask_gen #(.LINE_BYTES(LINE_BYTES), .ALLOW_CHOP(ALLOW_CHOP)) u_mask (
      .off(req_off), .len(req_len), .byte_en(byte_en),
      .bad(bad), .chop(chop), .upper(upper)
   );

   mbw_ctrl #(.BEATS(BEATS)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_bad(bad), .req_chop(chop), .req_upper(upper), .mode(merge_mode),
      .take(take), .req_err(req_err), .done(done),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_chop(cmd_chop), .cmd_half(cmd_half),
      .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_valid(rd_valid), .rd_take(rd_take), .merge_q(merge_q), .beat(beat)
   );

   mbw_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS)) u_buf (
      .clk(clk), .rst_n(rst_n), .load(take), .load_data(req_data),
      .load_be(byte_en), .rd_en(rd_take), .beat(beat), .rd_data(rd_data),
      .out_data(wr_data), .out_be(buf_be)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) line_q <= '0;
      else if (take) line_q <= req_line;
   end

   assign cmd_line = line_q;
   assign wr_mask  = merge_q ? '1 : buf_be;

   // R3: the enable vector counts exactly the requested bytes.
   a_r3_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !bad) |-> ($countones(byte_en) == int'(req_len)));

   // R9: a stalled command holds.
   a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
         (cmd_valid && $stable(cmd_write) && $stable(cmd_line) &&
          $stable(cmd_chop) && $stable(cmd_half)));

   // R9: a stalled write beat holds.
   a_r9_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_mask)));
endmodule

// File: tb/sim_mbw_line_writer.sv
`timescale 1ns/1ps
module sim_mbw_line_writer;
   localparam int DW = 32;
   localparam int NB = 4;
   localparam int AW = 8;
   localparam int BB = DW / 8;
   localparam int LB = BB * NB;
   localparam int OW = $clog2(LB);
   localparam int LW = OW + 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic merge_mode = 1'b0, req_valid = 1'b0;
   logic [AW-1:0] req_line = '0;
   logic [OW-1:0] req_off = '0;
   logic [LW-1:0] req_len = '0;
   logic [LB*8-1:0] req_data = '0;
   logic req_ready, req_err, done, cmd_valid, cmd_write, cmd_chop, cmd_half, wr_valid;
   logic [AW-1:0] cmd_line;
   logic [DW-1:0] wr_data;
   logic [BB-1:0] wr_mask;
   logic cmd_ready, wr_ready, rd_valid;
   logic [DW-1:0] rd_data;

   mbw_line_writer #(.DATA_W(DW), .BEATS(NB), .LADDR_W(AW), .ALLOW_CHOP(1'b1)) u0 (.*);

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [7:0] mem [LB];
   int cyc = 0, wcmd_cnt, rcmd_cnt, wbeats, rd_ret, rd_pend, rd_idx, wstart, wpos;
   int done_cnt, err_cnt, done_cyc, last_wr_cyc, order_bad, mask_bad, stall_bad = 0;
   bit merge_req, last_chop, last_half;
   logic [AW-1:0] last_line;
   bit cmd_stall = 0, wr_stall = 0;
   logic s_cw, s_chop, s_half;
   logic [AW-1:0] s_line;
   logic [DW-1:0] s_wd;
   logic [BB-1:0] s_wm;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Memory responder: drives ready/read inputs at the falling edge.
   initial begin
      cmd_ready = 1'b0; wr_ready = 1'b0; rd_valid = 1'b0; rd_data = '0;
      forever begin
         @(negedge clk);
         cyc++;
         if (cmd_stall && !(cmd_valid && cmd_write == s_cw && cmd_line == s_line &&
                            cmd_chop == s_chop && cmd_half == s_half)) stall_bad++;
         if (wr_stall && !(wr_valid && wr_data == s_wd && wr_mask == s_wm)) stall_bad++;
         if (rd_pend > 0 && (cyc % 5) != 3) begin
            rd_valid = 1'b1;
            for (int j = 0; j < BB; j++) rd_data[8*j +: 8] = mem[rd_idx*BB + j];
            rd_idx++; rd_pend--; rd_ret++;
         end else begin
            rd_valid = 1'b0;
         end
         cmd_ready = (cyc % 3) != 1;
         wr_ready  = (cyc % 4) != 2;
         cmd_stall = cmd_valid && !cmd_ready;
         s_cw = cmd_write; s_line = cmd_line; s_chop = cmd_chop; s_half = cmd_half;
         wr_stall = wr_valid && !wr_ready;
         s_wd = wr_data; s_wm = wr_mask;
         if (cmd_valid && cmd_ready) begin
            if (cmd_write) begin
               wcmd_cnt++;
               if (merge_req && rd_ret != NB) order_bad++;
               last_chop = cmd_chop; last_half = cmd_half; last_line = cmd_line;
               wstart = (cmd_chop && cmd_half) ? NB/2 : 0;
               wpos = 0;
            end else begin
               rcmd_cnt++;
               if (cmd_chop) order_bad++;
               rd_pend = NB; rd_idx = 0;
            end
         end
         if (wr_valid && wr_ready) begin
            for (int j = 0; j < BB; j++)
               if (wr_mask[j]) mem[(wstart + wpos)*BB + j] = wr_data[8*j +: 8];
            if (merge_req && wr_mask != '1) mask_bad++;
            wpos++; wbeats++; last_wr_cyc = cyc;
         end
         if (done) begin done_cnt++; done_cyc = cyc; end
         if (req_err) err_cnt++;
      end
   end

   task automatic run_req(input int off, input int len, input bit mode, input int seed);
      logic [7:0] oldv [LB];
      logic [7:0] newv [LB];
      bit legal, exp_chop, exp_half;
      int exp_beats, bad_bytes, t;
      legal = (len >= 1) && (off + len <= LB);
      exp_chop = !mode && legal && ((off + len <= LB/2) || (off >= LB/2));
      exp_half = exp_chop && (off >= LB/2);
      exp_beats = exp_chop ? NB/2 : NB;
      for (int i = 0; i < LB; i++) begin
         oldv[i] = 8'(seed*3 + i*17);
         newv[i] = oldv[i] ^ 8'h5A;
         mem[i] = oldv[i];
         req_data[8*i +: 8] = newv[i];
      end
      wcmd_cnt = 0; rcmd_cnt = 0; wbeats = 0; rd_ret = 0; rd_pend = 0;
      done_cnt = 0; err_cnt = 0; order_bad = 0; mask_bad = 0;
      done_cyc = 0; last_wr_cyc = -10;
      merge_req = mode;
      while (!req_ready) @(negedge clk);
      merge_mode = mode; req_valid = 1'b1;
      req_off = OW'(off); req_len = LW'(len); req_line = AW'(seed);
      @(negedge clk);
      req_valid = 1'b0;
      merge_mode = ~mode; // must be ignored after acceptance (R6)
      #1;
      if (legal) chk(req_ready == 1'b0, "R1 busy after accept", int'(req_ready), 0);
      else chk(err_cnt == 1, "R2 error pulse next cycle", err_cnt, 1);
      t = 0;
      while (done_cnt == 0 && err_cnt == 0 && t < 400) begin
         @(negedge clk); #1; t++;
      end
      repeat (3) @(negedge clk);
      #1;
      bad_bytes = 0;
      for (int i = 0; i < LB; i++) begin
         if (legal && i >= off && i < off + len) begin
            if (mem[i] !== newv[i]) bad_bytes++;
         end else if (mem[i] !== oldv[i]) bad_bytes++;
      end
      if (!legal) begin
         chk(err_cnt == 1 && done_cnt == 0, "R2 single error, no done", err_cnt*10 + done_cnt, 10);
         chk(wcmd_cnt + rcmd_cnt + wbeats == 0, "R2 no traffic", wcmd_cnt + rcmd_cnt + wbeats, 0);
         chk(bad_bytes == 0, "R2 memory unchanged", bad_bytes, 0);
      end else begin
         chk(err_cnt == 0, "R2 no error on legal request", err_cnt, 0);
         chk(bad_bytes == 0, mode ? "R6 merged line" : "R3 masked bytes", bad_bytes, 0);
         chk(wcmd_cnt == 1, "R5 one write command", wcmd_cnt, 1);
         chk(last_line == AW'(seed), "R5 line address", int'(last_line), seed % 256);
         chk(last_chop == exp_chop && last_half == exp_half, "R4 chop/half",
             int'(last_chop)*2 + int'(last_half), int'(exp_chop)*2 + int'(exp_half));
         chk(wbeats == exp_beats, "R4 write beat count", wbeats, exp_beats);
         chk(rcmd_cnt == (mode ? 1 : 0), "R6 read command count", rcmd_cnt, mode ? 1 : 0);
         if (mode) begin
            chk(mask_bad == 0, "R6 full mask", mask_bad, 0);
            chk(order_bad == 0 && rd_ret == NB, "R7 reads before write", rd_ret - order_bad*100, NB);
         end
         chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
         chk(done_cyc == last_wr_cyc + 1, "R8 done timing", done_cyc, last_wr_cyc + 1);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1;
      chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
      chk(!cmd_valid && !wr_valid, "R1 reset no traffic", int'(cmd_valid) + int'(wr_valid), 0);
      chk(!done && !req_err, "R1 reset no pulses", int'(done) + int'(req_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int m = 0; m < 2; m++)
         for (int o = 0; o < LB; o++)
            for (int l = 0; l <= LB + 2; l++)
               run_req(o, l, m[0], o*31 + l*7 + m);
      run_req(3, 31, 1'b0, 77);
      run_req(0, 31, 1'b1, 78);
      chk(stall_bad == 0, "R9 hold under stall", stall_bad, 0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule